// File: doc/BRIEF.md
# Bus Address Map Translator

This block sits between a peripheral controller's bus-address registers and system memory. It holds the controller's 16-bit bus byte address, the two extension bits that sit above it and the 16-bit negative word count. On a translate command it forms the 18-bit byte address and turns it into a word address. The upper part of the word address indexes an external 64-entry page map, and the lower part is the offset inside a 512-word page. The block reports the physical word address and how many words can be moved before the map must be consulted again.

The map is read through a synchronous read port, one entry per cycle. A transfer that runs past the end of a page walks the following entries. The burst stops early where consecutive entries do not name consecutive physical pages. The walk fails when it reaches an invalid entry or runs past the last entry. After the memory side has moved some words, a step command advances the byte address and the count, with the carry out of the 16-bit address going into the extension bits. The block then translates again for the rest of the transfer.

Top module: `busmap_xlate`

## Requirements
- R1: After reset `busy`, `done`, `err`, `bus_fault` and `map_rd` are low, and `burst_len`, `phys_addr`, `cur_addr`, `cur_ext` and `cur_cnt` are zero.
- R2: A load while idle writes `ld_addr`, `ld_ext` and `ld_cnt` into the address, extension and count registers on that edge. It also clears `bus_fault`, `burst_len` and `phys_addr`. A load while busy is ignored.
- R3: A translate with a count register of zero completes with `err` low and `burst_len` 0, even if the address is malformed, and it leaves `bus_fault` unchanged.
- R4: The full byte address is {extension, address} with the extension as bits 17:16. If bit 17 is set or bits 1:0 are nonzero, and the count is nonzero, the result is `err` with `bus_fault` set, and no map entry is read.
- R5: The word address is the byte address shifted right by 2. Its bits 14:9 index the map and its bits 8:0 are the page offset. A map entry has a valid flag in bit 11 and a physical page in bits 10:0. The physical address is page*512 + offset. An invalid first entry gives `err` with `bus_fault` set.
- R6: The word count is (65536 - count)/2 rounded down for a nonzero count register. When offset + words fits within 512, `burst_len` equals the word count.
- R7: When the transfer crosses into the next pages and every following entry names the previous physical page plus one, `burst_len` is the full word count. At the first entry that does not, `burst_len` is the number of words up to the end of the last page that was contiguous.
- R8: An invalid entry met during the walk, or a walk that needs an entry beyond index 63, gives `err` with `bus_fault` set.
- R9: A step of N words adds 4N to the byte address. A carry out of bit 15 increments the 2-bit extension field modulo 4, the count register increases by 2N modulo 65536, and the block then translates the updated registers on its own.
- R10: A step whose N is larger than the current `burst_len` gives `done` with `err` on the next edge. It changes no register and leaves `bus_fault` unchanged.
- R11: On a translate command `blk_cnt` becomes 0 if the word count is 0, 1 if `non_block` is high, and otherwise the word count divided by 128 rounded up.
- R12: Counting the edge that samples the command as edge 1, `done` is high after edge 2 for a zero count or a malformed address. It is high after edge 3+k when k map entries are examined, and after edge 1 for a rejected step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load the address, extension and count registers |
| ld_addr | input | 16 | Bus byte address to load |
| ld_ext | input | 2 | Extension bits (address bits 17:16) to load |
| ld_cnt | input | 16 | Two's-complement negative count to load |
| non_block | input | 1 | Drive is not block-addressed (block count forced to 1) |
| go | input | 1 | Translate the current registers |
| step_en | input | 1 | Advance by `step_n` words, then translate |
| step_n | input | 15 | Words moved in the last burst |
| map_rd | output | 1 | Map read enable |
| map_idx | output | 6 | Map index being read |
| map_entry | input | 12 | Entry read one cycle after `map_rd`: valid bit 11, page bits 10:0 |
| busy | output | 1 | A translation is in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Result is an error (valid with `done`) |
| bus_fault | output | 1 | Sticky control-bus error, cleared by a load |
| phys_addr | output | 20 | Physical word address of the burst |
| burst_len | output | 15 | Words that may move before a remap |
| blk_cnt | output | 9 | Block count of the transfer |
| cur_addr | output | 16 | Current bus byte address |
| cur_ext | output | 2 | Current extension bits |
| cur_cnt | output | 16 | Current count register |

## Verification
The hardest results to reach are the ones deep in the map walk. These are a burst cut short by a discontinuity two pages along, a walk that fails on the last map index, and a step whose address carry lands in the extension bits. The stimulus seeds the map with a deliberate discontinuity and an invalid entry. It then loads start addresses a few words before a page end, including in the final page. Separately, it steps a burst that starts just below a 64K boundary so that the carry, the zero count and the automatic retranslation meet in one command.

// File: rtl/busmap_pkg.sv
package busmap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHK,
    ST_FETCH,
    ST_EVAL
  } walk_st_e;
endpackage

// File: rtl/busmap_decode.sv
module busmap_decode #(
  parameter int ADDR_W = 16,
  parameter int EXT_W  = 2,
  parameter int OFF_W  = 9,
  parameter int BLK_SH = 7,
  localparam int CNT_W = ADDR_W,
  localparam int IDX_W = ADDR_W + EXT_W - 3 - OFF_W,
  localparam int WC_W  = CNT_W - 1,
  localparam int BLK_W = WC_W + 1 - BLK_SH
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [EXT_W-1:0]  ext,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              non_block,
  output logic              addr_bad,
  output logic              cnt_zero,
  output logic [IDX_W-1:0]  idx,
  output logic [OFF_W-1:0]  off,
  output logic [WC_W-1:0]   wc,
  output logic [BLK_W-1:0]  blk
);
  localparam int FULL_W = ADDR_W + EXT_W;
  localparam logic [WC_W:0] RND_ADD = (WC_W+1)'((1 << BLK_SH) - 1);

  logic [FULL_W-1:0] full;
  logic [CNT_W-1:0]  neg;
  logic [WC_W:0]     rnd;

  assign full     = {ext, addr};
  assign addr_bad = full[FULL_W-1] | (|full[1:0]);
  assign off      = full[OFF_W+1:2];
  assign idx      = full[OFF_W+IDX_W+1:OFF_W+2];
  assign cnt_zero = (cnt == '0);
  assign neg      = ~cnt + 1'b1;
  assign wc       = neg[CNT_W-1:1];
  assign rnd      = {1'b0, wc} + RND_ADD;

  always_comb begin
    if (wc == '0)     blk = '0;
    else if (non_block) blk = BLK_W'(1);
    else              blk = rnd[WC_W:BLK_SH];
  end
endmodule

// File: rtl/busmap_advance.sv
module busmap_advance #(
  parameter int ADDR_W = 16,
  parameter int EXT_W  = 2,
  localparam int CNT_W = ADDR_W,
  localparam int WC_W  = CNT_W - 1,
  localparam int SUM_W = WC_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_ok,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [EXT_W-1:0]  ld_ext,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              adv_en,
  input  logic [WC_W-1:0]   adv_n,
  output logic [ADDR_W-1:0] addr_q,
  output logic [EXT_W-1:0]  ext_q,
  output logic [CNT_W-1:0]  cnt_q
);
  logic [SUM_W-1:0] sum;
  logic             carry;

  assign sum   = SUM_W'(addr_q) + SUM_W'({adv_n, 2'b00});
  assign carry = |sum[SUM_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ext_q  <= '0;
      cnt_q  <= '0;
    end else if (ld_ok) begin
      addr_q <= ld_addr;
      ext_q  <= ld_ext;
      cnt_q  <= ld_cnt;
    end else if (adv_en) begin
      addr_q <= sum[ADDR_W-1:0];
      ext_q  <= ext_q + EXT_W'(carry);
      cnt_q  <= cnt_q + {adv_n, 1'b0};
    end
  end

  // R9
  ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_ok && !adv_en) |=> $stable(ext_q) && $stable(addr_q) && $stable(cnt_q));

  // R9
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !ld_ok) |=> (addr_q[1:0] == $past(addr_q[1:0])));
endmodule

// File: rtl/busmap_walk.sv
module busmap_walk
  import busmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int EXT_W  = 2,
  parameter int OFF_W  = 9,
  parameter int PAGE_W = 11,
  parameter int BLK_SH = 7,
  localparam int CNT_W  = ADDR_W,
  localparam int IDX_W  = ADDR_W + EXT_W - 3 - OFF_W,
  localparam int WC_W   = CNT_W - 1,
  localparam int BLK_W  = WC_W + 1 - BLK_SH,
  localparam int PHYS_W = PAGE_W + OFF_W,
  localparam int AV_W   = WC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_ok,
  input  logic              go,
  input  logic              step_en,
  input  logic [WC_W-1:0]   step_n,
  input  logic              addr_bad,
  input  logic              cnt_zero,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  off,
  input  logic [WC_W-1:0]   wc,
  input  logic [BLK_W-1:0]  blk,
  input  logic [PAGE_W:0]   map_entry,
  output logic              adv_en,
  output logic              map_rd,
  output logic [IDX_W-1:0]  map_idx,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              bus_fault,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [WC_W-1:0]   burst_len,
  output logic [BLK_W-1:0]  blk_cnt
);
  localparam logic [AV_W-1:0] PG_WORDS = AV_W'(1 << OFF_W);

  walk_st_e          state;
  logic [IDX_W-1:0]  idx_q;
  logic              cur_last;
  logic              first_q;
  logic [PAGE_W-1:0] prev_pg;
  logic [AV_W-1:0]   avail;
  logic [AV_W-1:0]   avail_nxt;
  logic              ent_vld;
  logic [PAGE_W-1:0] ent_pg;
  logic              ent_seq;
  logic              step_big;

  assign ent_vld   = map_entry[PAGE_W];
  assign ent_pg    = map_entry[PAGE_W-1:0];
  assign ent_seq   = ({1'b0, ent_pg} == ({1'b0, prev_pg} + 1'b1));
  assign avail_nxt = first_q ? (PG_WORDS - {{(AV_W-OFF_W){1'b0}}, off})
                             : (avail + PG_WORDS);
  assign step_big  = (step_n > burst_len);
  assign adv_en    = (state == ST_IDLE) && !ld_ok && step_en && !step_big;
  assign map_rd    = (state == ST_FETCH) || (state == ST_EVAL);
  assign map_idx   = idx_q;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx_q     <= '0;
      cur_last  <= 1'b0;
      first_q   <= 1'b0;
      prev_pg   <= '0;
      avail     <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      bus_fault <= 1'b0;
      phys_addr <= '0;
      burst_len <= '0;
      blk_cnt   <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ld_ok) begin
            bus_fault <= 1'b0;
            burst_len <= '0;
            phys_addr <= '0;
          end else if (step_en) begin
            if (step_big) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              state <= ST_CHK;
            end
          end else if (go) begin
            blk_cnt <= blk;
            state   <= ST_CHK;
          end
        end
        ST_CHK: begin
          burst_len <= '0;
          phys_addr <= '0;
          if (cnt_zero) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (addr_bad) begin
            done      <= 1'b1;
            err       <= 1'b1;
            bus_fault <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            idx_q   <= idx;
            first_q <= 1'b1;
            state   <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          idx_q    <= idx_q + 1'b1;
          cur_last <= &idx_q;
          state    <= ST_EVAL;
        end
        ST_EVAL: begin
          idx_q    <= idx_q + 1'b1;
          cur_last <= &idx_q;
          first_q  <= 1'b0;
          if (!ent_vld) begin
            done      <= 1'b1;
            err       <= 1'b1;
            bus_fault <= 1'b1;
            phys_addr <= '0;
            state     <= ST_IDLE;
          end else if (!first_q && !ent_seq) begin
            done      <= 1'b1;
            burst_len <= avail[WC_W-1:0];
            state     <= ST_IDLE;
          end else begin
            prev_pg <= ent_pg;
            avail   <= avail_nxt;
            if (first_q) phys_addr <= {ent_pg, off};
            if (avail_nxt >= {1'b0, wc}) begin
              done      <= 1'b1;
              burst_len <= wc;
              state     <= ST_IDLE;
            end else if (cur_last) begin
              done      <= 1'b1;
              err       <= 1'b1;
              bus_fault <= 1'b1;
              phys_addr <= '0;
              state     <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  // R3
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CHK && cnt_zero) |=> done && !err && (burst_len == '0));

  // R4
  bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CHK && !cnt_zero && addr_bad) |=> done && err && bus_fault && !map_rd);

  // R6
  burst_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (burst_len <= wc));

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done && !busy);

  // R10
  step_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !ld_ok && step_en && step_big) |=> done && err && $stable(bus_fault));
endmodule

// File: rtl/busmap_xlate.sv
module busmap_xlate #(
  parameter int ADDR_W = 16,
  parameter int EXT_W  = 2,
  parameter int OFF_W  = 9,
  parameter int PAGE_W = 11,
  parameter int BLK_SH = 7,
  localparam int CNT_W  = ADDR_W,
  localparam int IDX_W  = ADDR_W + EXT_W - 3 - OFF_W,
  localparam int WC_W   = CNT_W - 1,
  localparam int BLK_W  = WC_W + 1 - BLK_SH,
  localparam int PHYS_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [EXT_W-1:0]  ld_ext,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              non_block,
  input  logic              go,
  input  logic              step_en,
  input  logic [WC_W-1:0]   step_n,
  output logic              map_rd,
  output logic [IDX_W-1:0]  map_idx,
  input  logic [PAGE_W:0]   map_entry,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              bus_fault,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [WC_W-1:0]   burst_len,
  output logic [BLK_W-1:0]  blk_cnt,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [EXT_W-1:0]  cur_ext,
  output logic [CNT_W-1:0]  cur_cnt
);
  logic             ld_ok;
  logic             adv_en;
  logic             addr_bad;
  logic             cnt_zero;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;
  logic [WC_W-1:0]  wc;
  logic [BLK_W-1:0] blk;

  assign ld_ok = ld_en & ~busy;

  busmap_advance #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_adv (
    .clk(clk), .rst(rst), .ld_ok(ld_ok),
    .ld_addr(ld_addr), .ld_ext(ld_ext), .ld_cnt(ld_cnt),
    .adv_en(adv_en), .adv_n(step_n),
    .addr_q(cur_addr), .ext_q(cur_ext), .cnt_q(cur_cnt)
  );

  busmap_decode #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .OFF_W(OFF_W), .BLK_SH(BLK_SH)) u_dec (
    .addr(cur_addr), .ext(cur_ext), .cnt(cur_cnt), .non_block(non_block),
    .addr_bad(addr_bad), .cnt_zero(cnt_zero), .idx(idx), .off(off),
    .wc(wc), .blk(blk)
  );

  busmap_walk #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .OFF_W(OFF_W),
                .PAGE_W(PAGE_W), .BLK_SH(BLK_SH)) u_walk (
    .clk(clk), .rst(rst), .ld_ok(ld_ok), .go(go),
    .step_en(step_en), .step_n(step_n),
    .addr_bad(addr_bad), .cnt_zero(cnt_zero), .idx(idx), .off(off),
    .wc(wc), .blk(blk), .map_entry(map_entry),
    .adv_en(adv_en), .map_rd(map_rd), .map_idx(map_idx), .busy(busy),
    .done(done), .err(err), .bus_fault(bus_fault), .phys_addr(phys_addr),
    .burst_len(burst_len), .blk_cnt(blk_cnt)
  );
endmodule

// File: tb/busmap_xlate_bench.sv
`timescale 1ns/1ps
module busmap_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [15:0] ld_addr = '0;
  logic [1:0]  ld_ext = '0;
  logic [15:0] ld_cnt = '0;
  logic        non_block = 1'b0;
  logic        go = 1'b0;
  logic        step_en = 1'b0;
  logic [14:0] step_n = '0;
  logic        map_rd;
  logic [5:0]  map_idx;
  logic [11:0] map_entry;
  logic        busy, done, err, bus_fault;
  logic [19:0] phys_addr;
  logic [14:0] burst_len;
  logic [8:0]  blk_cnt;
  logic [15:0] cur_addr;
  logic [1:0]  cur_ext;
  logic [15:0] cur_cnt;

  always #4 clk = ~clk;

  busmap_xlate u_busmap_xlate (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_ext(ld_ext),
    .ld_cnt(ld_cnt), .non_block(non_block), .go(go), .step_en(step_en),
    .step_n(step_n), .map_rd(map_rd), .map_idx(map_idx), .map_entry(map_entry),
    .busy(busy), .done(done), .err(err), .bus_fault(bus_fault),
    .phys_addr(phys_addr), .burst_len(burst_len), .blk_cnt(blk_cnt),
    .cur_addr(cur_addr), .cur_ext(cur_ext), .cur_cnt(cur_cnt)
  );

  logic [11:0] mem [0:63];
  always_ff @(posedge clk) if (map_rd) map_entry <= mem[map_idx];

  int checks = 0;
  int failures = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct {
    string tag;
    int err; int burst; int phys; int lat; int blk; int fault;
    int addr; int ext; int cnt;
  } exp_t;

  exp_t q[$];
  int   pending = 0;
  int   lat_cnt = 0;
  bit   armed = 1'b0;

  // shadow of the registers, from the requirements
  int m_addr = 0, m_ext = 0, m_cnt = 0, m_burst = 0, m_fault = 0;

  function automatic exp_t model(input int a, input int x, input int c);
    exp_t e;
    int full, w, pg, off, wc, avail, prev;
    bit fin;
    e.err = 0; e.burst = 0; e.phys = 0; e.lat = 2;
    if (c == 0) return e;
    if (x >= 2 || (a % 4) != 0) begin e.err = 1; return e; end
    full = x * 65536 + a;
    w = full / 4; pg = w / 512; off = w % 512;
    wc = (65536 - c) / 2;
    avail = 512 - off; prev = 0; fin = 0;
    for (int k = pg; k < 64 && !fin; k++) begin
      e.lat = 3 + (k - pg + 1);
      if (mem[k][11] == 1'b0) begin
        e.err = 1; e.phys = 0; fin = 1;
      end else if (k != pg && int'(mem[k][10:0]) != prev + 1) begin
        e.burst = avail; fin = 1;
      end else begin
        if (k == pg) e.phys = int'(mem[k][10:0]) * 512 + off;
        else avail += 512;
        prev = int'(mem[k][10:0]);
        if (avail >= wc) begin e.burst = wc; fin = 1; end
        else if (k == 63) begin e.err = 1; e.phys = 0; fin = 1; end
      end
    end
    return e;
  endfunction

  function automatic int blk_model(input int c, input bit nb);
    int wc;
    wc = (c == 0) ? 0 : (65536 - c) / 2;
    if (wc == 0) return 0;
    if (nb) return 1;
    return (wc + 127) / 128;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (armed) begin
      lat_cnt++;
      if (done) begin
        exp_t e;
        e = q.pop_front();
        armed = 1'b0;
        chk({e.tag, " R12 latency"}, lat_cnt, e.lat);
        chk({e.tag, " err"}, int'(err), e.err);
        chk({e.tag, " burst"}, int'(burst_len), e.burst);
        if (e.err == 0) chk({e.tag, " R5 phys"}, int'(phys_addr), e.phys);
        chk({e.tag, " bus_fault"}, int'(bus_fault), e.fault);
        chk({e.tag, " R9 addr"}, int'(cur_addr), e.addr);
        chk({e.tag, " R9 ext"}, int'(cur_ext), e.ext);
        chk({e.tag, " R9 cnt"}, int'(cur_cnt), e.cnt);
        if (e.blk >= 0) chk({e.tag, " R11 blk"}, int'(blk_cnt), e.blk);
        pending--;
      end
    end else if (done) begin
      chk("unexpected done", 1, 0);
    end
  end

  task automatic load(input int a, input int x, input int c);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 16'(a); ld_ext = 2'(x); ld_cnt = 16'(c);
    @(negedge clk);
    ld_en = 1'b0;
    m_addr = a; m_ext = x; m_cnt = c; m_burst = 0; m_fault = 0;
    chk("R2 load addr", int'(cur_addr), a);
    chk("R2 load ext", int'(cur_ext), x);
    chk("R2 load cnt", int'(cur_cnt), c);
    chk("R2 fault cleared", int'(bus_fault), 0);
    chk("R2 burst cleared", int'(burst_len), 0);
  endtask

  task automatic send(input bit is_step, input int n, input string tag);
    exp_t e;
    int na, nx, nc, s;
    na = m_addr; nx = m_ext; nc = m_cnt;
    if (is_step && n > m_burst) begin
      e.err = 1; e.burst = m_burst; e.phys = 0; e.lat = 1; e.fault = m_fault;
    end else begin
      if (is_step) begin
        s = m_addr + 4 * n;
        if (s > 65535) nx = (m_ext + 1) % 4;
        na = s % 65536;
        nc = (m_cnt + 2 * n) % 65536;
      end
      e = model(na, nx, nc);
      e.fault = m_fault | e.err;
    end
    e.tag = tag; e.addr = na; e.ext = nx; e.cnt = nc;
    e.blk = is_step ? -1 : blk_model(nc, non_block);
    q.push_back(e);
    pending++;
    @(negedge clk);
    if (is_step) begin step_en = 1'b1; step_n = 15'(n); end
    else go = 1'b1;
    #1;
    lat_cnt = 0; armed = 1'b1;
    @(negedge clk);
    go = 1'b0; step_en = 1'b0;
    while (pending != 0) @(negedge clk);
    m_addr = na; m_ext = nx; m_cnt = nc; m_fault = e.fault;
    if (!(is_step && e.lat == 1)) m_burst = e.err ? 0 : e.burst;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = {1'b1, 11'(100 + i)};
    mem[5] = {1'b1, 11'd300};
    mem[8] = 12'h000;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 fault", int'(bus_fault), 0);
    chk("R1 map_rd", int'(map_rd), 0);
    chk("R1 burst", int'(burst_len), 0);
    chk("R1 phys", int'(phys_addr), 0);
    chk("R1 regs", int'(cur_addr) + int'(cur_ext) + int'(cur_cnt), 0);

    // R3 zero count wins over a malformed address
    load(16'h0003, 0, 0);
    send(0, 0, "R3 zero count");
    // R4 low address bits
    load(16'h0002, 0, 16'hFFF0);
    send(0, 0, "R4 low bits");
    // R4 bit 17
    load(16'h0000, 2, 16'hFFF0);
    send(0, 0, "R4 bit17");
    // R5 R6 single page, even and odd count
    load(16'h0828, 0, 16'hFF38);
    send(0, 0, "R6 single page");
    load(16'h0828, 0, 16'hFF37);
    send(0, 0, "R6 odd count");
    // R11 block counts
    load(16'h0000, 0, 65536 - 600);
    send(0, 0, "R11 three blocks");
    non_block = 1'b1;
    send(0, 0, "R11 non-block");
    non_block = 1'b0;
    load(16'h0000, 0, 16'hFFFF);
    send(0, 0, "R11 zero words");
    // R7 contiguous and broken crossings
    load(16'h0FD0, 0, 16'hFF38);
    send(0, 0, "R7 contiguous");
    load(16'h27D0, 0, 16'hFF38);
    send(0, 0, "R7 discontinuity");
    // R8 invalid later entry, R5 invalid first entry
    load(16'h3FD0, 0, 16'hFF38);
    send(0, 0, "R8 invalid later");
    load(16'h4000, 0, 16'hFF38);
    send(0, 0, "R5 invalid first");
    // R8 walk past the last index
    load(16'hFFD0, 1, 16'hFF38);
    send(0, 0, "R8 past end");
    // R9 step with retranslation, then R10 oversize step
    load(16'h0828, 0, 16'hFF38);
    send(0, 0, "R9 base");
    send(1, 40, "R9 step");
    send(1, 61, "R10 oversize step");
    // R9 carry into extension, ending at zero count
    load(16'hFFF0, 0, 16'hFFF0);
    send(0, 0, "R9 cross base");
    send(1, 8, "R9 carry step");
    load(16'hFFFC, 1, 16'hFFFE);
    send(0, 0, "R9 ext base");
    send(1, 1, "R9 ext carry");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule